// File: doc/BRIEF.md
# Card Information Structure Tuple Finder

This engine looks for one tuple code in the chain of tuples that a removable card keeps in its information structure. A single start pulse latches the wanted code and the largest body length the caller accepts. The engine then reads bytes through a narrow memory port and walks the chain, one type/link pair at a time. When it finds the code, it sends the tuple body out as a stream of bytes. It finishes with a one-cycle completion pulse that carries a found flag and a byte count.

The chain is searched twice at most. The first pass reads the attribute space, where only every second physical byte holds data. If that pass gives up, a second pass reads common memory, where bytes are packed. Each pass stops when it meets an end marker, when it reaches the end of the scannable range, or when it has visited too many tuples. The engine does not interpret the body bytes; that is left to the consumer.

Top module: `cis_tuple_walker`

## Requirements
- R1: A tuple at logical position p has its type byte at p and its link byte at p+1. A tuple that does not match leads to the next tuple at p+2+link. The engine reads exactly the type and link bytes of each visited tuple, plus the body bytes it copies.
- R2: A type byte of 0xFF ends the current pass as not-found. A link byte of 0xFF also ends the pass as not-found, and this check happens before the type is compared with the wanted code.
- R3: In attribute space (mem_attr=1), logical position p is read at mem_addr = 2*p, so the address is always even. In common memory (mem_attr=0), position p is read at mem_addr = p.
- R4: No position at or above 8192 is read. A pass that needs such a position for a type or link byte ends as not-found. A body that runs past position 8191 is cut short there, and count reports only the bytes actually delivered.
- R5: A pass visits at most 1000 tuples. Once 1000 tuples have been skipped, the pass ends as not-found without reading another byte.
- R6: On a match, the engine delivers min(max_len, link) body bytes. The bytes appear on body_byte with a one-cycle body_valid strobe, in ascending position order, one strobe per completed read in the cycle after mem_valid. Count equals the number of bytes delivered and never exceeds max_len.
- R7: Attribute space is always searched first. Common memory is searched only after the attribute pass ends as not-found, and the engine never returns to attribute space during that search. An overall miss reports found=0 and count=0.
- R8: Only one read is outstanding at a time. mem_req is a one-cycle pulse with mem_addr and mem_attr valid in that cycle. The next pulse comes only after mem_valid has returned the data. mem_valid has no effect when no read is pending.
- R9: done is a one-cycle pulse. found and count are valid with it and hold their value until the next done. busy is high from the cycle after start is accepted until done.
- R10: A start pulse while busy is high is ignored. The search in progress completes with its original code and length.
- R11: After reset, busy, done, mem_req, body_valid, found and count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search; accepted only while idle |
| code | input | 8 | Tuple code to find, latched at start |
| max_len | input | 8 | Largest body length to copy, latched at start |
| busy | output | 1 | Search in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_attr | output | 1 | 1 = attribute space, 0 = common memory |
| mem_addr | output | 14 | Physical byte address of the read |
| mem_valid | input | 1 | Read data returned |
| mem_rdata | input | 8 | Read data |
| body_valid | output | 1 | body_byte carries a body byte |
| body_byte | output | 8 | Tuple body byte |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Tuple found, valid with done |
| count | output | 8 | Body bytes delivered, valid with done |

## Verification
The assertions assume that the memory side raises mem_valid only for a read it has accepted, and at most once for each request. The bench memory model sees a request at a falling edge and answers exactly once, one to three cycles later. It never raises mem_valid on its own. Start pulses come from a task that always waits for done, except for the one test that deliberately pulses start while busy is high.

// File: rtl/cis_tuple_walker.sv
module cis_tuple_walker #(
  parameter int ADDR_W     = 14,
  parameter int POS_SPAN   = 8192,
  parameter int MAX_TUPLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        code,
  input  logic [7:0]        max_len,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_attr,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_rdata,
  output logic              body_valid,
  output logic [7:0]        body_byte,
  output logic              done,
  output logic              found,
  output logic [7:0]        count
);
  localparam int POS_W = $clog2(POS_SPAN) + 1;
  localparam int TUP_W = $clog2(MAX_TUPLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_TYPE, ST_LINK, ST_BODY} state_t;

  state_t            state;
  logic              attr_q, pend;
  logic [POS_W-1:0]  pos_q;
  logic [TUP_W-1:0]  ntup_q;
  logic [7:0]        code_q, max_q, type_q, left_q, cnt_q;
  logic              done_q, found_q, bvalid_q;
  logic [7:0]        count_q, bbyte_q;

  logic at_end, tup_full, want, take, give_up, body_end, miss, is_end_byte;
  logic [7:0] link_min;

  assign at_end      = pos_q >= POS_W'(POS_SPAN);
  assign tup_full    = ntup_q == TUP_W'(MAX_TUPLES);
  assign is_end_byte = mem_rdata == 8'hFF;
  assign want        = ((state == ST_TYPE) && !at_end && !tup_full) ||
                       (((state == ST_LINK) || (state == ST_BODY)) && !at_end);
  assign take        = pend && mem_valid;
  assign give_up     = !pend && (((state == ST_TYPE) && (at_end || tup_full)) ||
                                 ((state == ST_LINK) && at_end));
  assign body_end    = !pend && (state == ST_BODY) && at_end;
  assign miss        = give_up ||
                       (take && ((state == ST_TYPE) || (state == ST_LINK)) && is_end_byte);
  assign link_min    = (mem_rdata < max_q) ? mem_rdata : max_q;

  assign busy       = state != ST_IDLE;
  assign mem_req    = want && !pend;
  assign mem_attr   = attr_q;
  assign mem_addr   = attr_q ? ADDR_W'({pos_q, 1'b0}) : ADDR_W'(pos_q);
  assign body_valid = bvalid_q;
  assign body_byte  = bbyte_q;
  assign done       = done_q;
  assign found      = found_q;
  assign count      = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      attr_q   <= 1'b1;
      pend     <= 1'b0;
      pos_q    <= '0;
      ntup_q   <= '0;
      code_q   <= '0;
      max_q    <= '0;
      type_q   <= '0;
      left_q   <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
      count_q  <= '0;
      bvalid_q <= 1'b0;
      bbyte_q  <= '0;
    end else begin
      done_q   <= 1'b0;
      bvalid_q <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          code_q <= code;
          max_q  <= max_len;
          attr_q <= 1'b1;
          pos_q  <= '0;
          ntup_q <= '0;
          cnt_q  <= '0;
          state  <= ST_TYPE;
        end
      end else begin
        if (mem_req) begin
          pend  <= 1'b1;
          pos_q <= pos_q + 1'b1;
        end
        if (take) pend <= 1'b0;
        if (miss) begin
          if (attr_q) begin
            attr_q <= 1'b0;
            pos_q  <= '0;
            ntup_q <= '0;
            state  <= ST_TYPE;
          end else begin
            done_q  <= 1'b1;
            found_q <= 1'b0;
            count_q <= '0;
            state   <= ST_IDLE;
          end
        end else if (take) begin
          case (state)
            ST_TYPE: begin
              type_q <= mem_rdata;
              state  <= ST_LINK;
            end
            ST_LINK: begin
              if (type_q == code_q) begin
                left_q <= link_min;
                if (link_min == 8'd0) begin
                  done_q  <= 1'b1;
                  found_q <= 1'b1;
                  count_q <= '0;
                  state   <= ST_IDLE;
                end else begin
                  state <= ST_BODY;
                end
              end else begin
                pos_q  <= pos_q + POS_W'(mem_rdata);
                ntup_q <= ntup_q + 1'b1;
                state  <= ST_TYPE;
              end
            end
            ST_BODY: begin
              bvalid_q <= 1'b1;
              bbyte_q  <= mem_rdata;
              cnt_q    <= cnt_q + 1'b1;
              left_q   <= left_q - 1'b1;
              if (left_q == 8'd1) begin
                done_q  <= 1'b1;
                found_q <= 1'b1;
                count_q <= cnt_q + 1'b1;
                state   <= ST_IDLE;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end else if (body_end) begin
          done_q  <= 1'b1;
          found_q <= 1'b1;
          count_q <= cnt_q;
          state   <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/cis_tuple_walker_chk.sv
module cis_tuple_walker_chk #(
  parameter int ADDR_W   = 14,
  parameter int POS_SPAN = 8192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        max_len,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_attr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              body_valid,
  input logic              done,
  input logic              found,
  input logic [7:0]        count
);
  logic       pend_c, first_c, common_c;
  logic [7:0] max_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_c   <= 1'b0;
      first_c  <= 1'b0;
      common_c <= 1'b0;
      max_c    <= '0;
    end else begin
      if (mem_req) pend_c <= 1'b1;
      else if (mem_valid) pend_c <= 1'b0;
      if (start && !busy) begin
        first_c  <= 1'b1;
        common_c <= 1'b0;
        max_c    <= max_len;
      end else if (mem_req) begin
        first_c <= 1'b0;
        if (!mem_attr) common_c <= 1'b1;
      end
    end
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !pend_c); // R8
  AST_ATTR_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_attr) |-> !mem_addr[0]); // R3
  AST_COMMON_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_attr) |-> (int'(mem_addr) < POS_SPAN)); // R4
  AST_ATTR_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && first_c) |-> mem_attr); // R7
  AST_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && common_c) |-> !mem_attr); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && !found) |-> (count == 8'd0)); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (done && found) |-> (count <= max_c)); // R6
  AST_BODY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) body_valid |-> $past(mem_valid)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R9
endmodule

bind cis_tuple_walker cis_tuple_walker_chk #(.ADDR_W(ADDR_W), .POS_SPAN(POS_SPAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .max_len(max_len), .busy(busy),
  .mem_req(mem_req), .mem_attr(mem_attr), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .body_valid(body_valid), .done(done), .found(found), .count(count)
);

// File: tb/cis_tuple_walker_test.sv
module cis_tuple_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] code = '0, max_len = '0;
  logic busy, mem_req, mem_attr, mem_valid, body_valid, done, found;
  logic [13:0] mem_addr;
  logic [7:0] mem_rdata, body_byte, count;

  always #2.5 clk = ~clk;

  cis_tuple_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code), .max_len(max_len),
    .busy(busy), .mem_req(mem_req), .mem_attr(mem_attr), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .body_valid(body_valid),
    .body_byte(body_byte), .done(done), .found(found), .count(count)
  );

  int checks = 0, fails = 0;
  int mode = 0, nfill = 0, lat = 1;
  int nreads = 0, bad_addr = 0, max_pos = 0;
  int nb = 0;
  logic [7:0] bq [256];
  logic got_done = 1'b0, d_found = 1'b0;
  logic [7:0] d_count = '0;
  logic [7:0] img_a [32];
  logic [7:0] img_c [32];

  // vector: code, max, found, count, attr space, body position, reads
  localparam logic [55:0] VEC [9] = '{
    {8'h15, 8'd10,  8'd1, 8'd4, 8'd1, 8'd7,  8'd8},
    {8'h15, 8'd2,   8'd1, 8'd2, 8'd1, 8'd7,  8'd6},
    {8'h1A, 8'd255, 8'd1, 8'd2, 8'd1, 8'd13, 8'd8},
    {8'h20, 8'd5,   8'd1, 8'd0, 8'd1, 8'd0,  8'd8},
    {8'h01, 8'd3,   8'd1, 8'd3, 8'd1, 8'd2,  8'd5},
    {8'h1B, 8'd8,   8'd1, 8'd5, 8'd0, 8'd2,  8'd16},
    {8'h40, 8'd4,   8'd0, 8'd0, 8'd0, 8'd0,  8'd15},
    {8'h77, 8'd4,   8'd0, 8'd0, 8'd0, 8'd0,  8'd15},
    {8'h15, 8'd0,   8'd1, 8'd0, 8'd1, 8'd0,  8'd4}
  };

  function automatic logic [7:0] byte_at(input logic a, input int p);
    if (mode == 0) return (p < 32) ? (a ? img_a[p] : img_c[p]) : 8'hFF;
    if (mode == 1) begin
      if (a) begin
        if (p < 2 * nfill) return 8'h00;
        if (p == 2 * nfill) return 8'h05;
        if (p == 2 * nfill + 1) return 8'h01;
        return 8'h5A;
      end
      if (p == 0) return 8'h05;
      if (p == 1) return 8'h02;
      return 8'hC3;
    end
    if (a) return (p == 8190) ? 8'h33 : 8'h10;
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory model
  initial begin
    mem_valid = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_valid = 1'b0;
      if (rst_n && mem_req) begin
        int p;
        logic a;
        a = mem_attr;
        if (a && mem_addr[0]) bad_addr++;
        p = a ? int'(mem_addr) / 2 : int'(mem_addr);
        if (p > max_pos) max_pos = p;
        nreads++;
        repeat (lat) @(negedge clk);
        mem_rdata = byte_at(a, p);
        mem_valid = 1'b1;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (body_valid) begin
        bq[nb] = body_byte;
        nb++;
      end
      if (done) begin
        got_done = 1'b1;
        d_found = found;
        d_count = count;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic launch(input logic [7:0] c, input logic [7:0] m);
    nb = 0; nreads = 0; max_pos = 0; got_done = 1'b0;
    @(negedge clk);
    code = c; max_len = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 50000 && !got_done; t++) @(negedge clk);
    #1;
    if (!got_done) begin
      fails++;
      $display("FAIL R9 no done actual=0 expected=1");
    end
  endtask

  task automatic run(input logic [7:0] c, input logic [7:0] m);
    launch(c, m);
    wait_done();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      img_a[i] = 8'h80 | 8'(i);
      img_c[i] = 8'h40 | 8'(i);
    end
    img_a[0] = 8'h01; img_a[1] = 8'd3;
    img_a[5] = 8'h15; img_a[6] = 8'd4;
    img_a[11] = 8'h1A; img_a[12] = 8'd2;
    img_a[15] = 8'h20; img_a[16] = 8'd0;
    img_a[17] = 8'hFF;
    img_c[0] = 8'h1B; img_c[1] = 8'd5;
    img_c[7] = 8'h15; img_c[8] = 8'd1;
    img_c[10] = 8'h40; img_c[11] = 8'hFF;

    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 mem_req", mem_req, 0);
    chk("R11 done", done, 0);
    chk("R11 body_valid", body_valid, 0);
    chk("R11 found/count", {found, count}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int l = 1; l <= 3; l += 2) begin
      lat = l;
      for (int v = 0; v < 9; v++) begin
        logic [55:0] e;
        e = VEC[v];
        run(e[55:48], e[47:40]);
        chk("R6 R7 found", d_found, int'(e[39:32]));
        chk("R6 count", d_count, int'(e[31:24]));
        chk("R6 strobes", nb, int'(e[31:24]));
        chk("R1 R2 reads", nreads, int'(e[7:0]));
        for (int k = 0; k < nb; k++)
          chk("R6 body byte", bq[k], byte_at(e[16], int'(e[15:8]) + k));
      end
    end
    chk("R3 attr addresses even", bad_addr, 0);

    mode = 1; lat = 2;
    nfill = 999;
    run(8'h05, 8'd8);
    chk("R5 found at tuple 1000", d_found, 1);
    chk("R5 count", d_count, 1);
    chk("R5 body", bq[0], 8'h5A);
    chk("R5 reads", nreads, 2001);
    nfill = 1000;
    run(8'h05, 8'd8);
    chk("R5 R7 fallback found", d_found, 1);
    chk("R5 R7 fallback count", d_count, 2);
    chk("R5 R7 fallback byte", bq[1], 8'hC3);
    chk("R5 no read past limit", nreads, 2004);

    launch(8'h05, 8'd8);
    repeat (40) @(negedge clk);
    code = 8'h01; max_len = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    @(negedge clk);
    chk("R10 start ignored found", d_found, 1);
    chk("R10 start ignored count", d_count, 2);
    chk("R9 idle after done", busy, 0);

    mode = 2; lat = 1;
    run(8'h44, 8'd4);
    chk("R4 end of span miss", {d_found, d_count}, 0);
    chk("R4 reads", nreads, 913);
    chk("R4 highest position", max_pos, 8191);
    run(8'h33, 8'd16);
    chk("R4 truncated body found", d_found, 1);
    chk("R4 truncated body count", d_count, 0);
    chk("R4 truncated strobes", nb, 0);
    chk("R3 attr addresses even", bad_addr, 0);

    finish_run();
  end
endmodule